// File: doc/BRIEF.md
# Field-Synchronized Output Enable Controller

This block produces the output enables for two groups of digital outputs on a video sensor. The first group carries the frame-start and line-start strobes. The second group carries the qualifier clock. A control register sits behind a simple write/read port, and it holds one tri-state bit for each group. The strobe and clock data pass through the block unchanged. The block only decides whether each group is driven.

Each group has a composite disable. It is the OR of that group's register bit and an external active-high output-disable pin. The pin passes through a two-flop synchronizer first, and its effect is never held back. A configuration input selects when a register change reaches the outputs. It can take effect on the cycle after the write, or it can wait for the next field boundary, which a single-cycle field-start pulse marks. Readback always returns the value most recently written, even while the change to the output is still waiting.

Top module: `field_oe_ctrl`

## Requirements
- R1: After reset, both control bits read back as 0, and both `strobe_oe` and `qclk_oe` are 1 (driven).
- R2: A write to the control address (default 0x2) updates the readback on the next cycle in both timing modes. Bit 5 is the strobe-group tri-state bit and bit 6 is the qualifier-clock tri-state bit. All other readback bits are 0.
- R3: Data bits other than 5 and 6 in a control write have no effect on the readback or on either enable.
- R4: With `retime_en` = 0, a written bit reaches its group's enable on the cycle after the write.
- R5: With `retime_en` = 1, the enables hold their values until a cycle in which `field_start` is 1. Pending values, including a write made in that same cycle, apply on the following cycle.
- R6: When several writes arrive before one field boundary, only the last written value is applied at that boundary.
- R7: A group's enable is 0 whenever the synchronized `ext_disable` or that group's applied bit is 1. A change on the pin appears at the enables two cycles later, whatever the timing mode and whether or not `field_start` is seen.
- R8: Bit 5 affects only `strobe_oe`, and bit 6 affects only `qclk_oe`.
- R9: A write to any other address changes neither the control readback nor the enables, and a read of any other address returns 0.
- R10: `fst_out`, `lst_out` and `qclk_out` follow `fst_in`, `lst_in` and `qclk_in` combinationally, whatever the enable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Readback of the addressed register |
| retime_en | input | 1 | 1 = defer changes to the field boundary, 0 = apply on the next cycle |
| field_start | input | 1 | Single-cycle field boundary pulse |
| ext_disable | input | 1 | Asynchronous active-high output-disable pin |
| fst_in | input | 1 | Frame-start strobe data |
| lst_in | input | 1 | Line-start strobe data |
| qclk_in | input | 1 | Qualifier clock data |
| fst_out | output | 1 | Frame-start strobe to pad |
| lst_out | output | 1 | Line-start strobe to pad |
| qclk_out | output | 1 | Qualifier clock to pad |
| strobe_oe | output | 1 | Active-high enable for the frame/line strobe pads |
| qclk_oe | output | 1 | Active-high enable for the qualifier clock pad |

## Verification
The bench builds the block with its default parameters: a 4-bit address, an 8-bit data word, the control register at 0x2, and the tri-state bits at positions 5 and 6. With these values, a write that sets every bit can be told apart from one that sets only the two live bits. A neighbouring address can serve to show that writes elsewhere are ignored. The stimulus table covers switching between the two timing modes while a change is pending, a write that coincides with the field pulse, and several writes that overwrite each other before one boundary. The directed tests cover the two-cycle pin latency while a deferred change is waiting, and a reset applied with bits set.

// File: rtl/field_oe_ctrl.sv
module field_oe_ctrl #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h2,
  parameter int STRB_BIT = 5,
  parameter int QCK_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              retime_en,
  input  logic              field_start,
  input  logic              ext_disable,
  input  logic              fst_in,
  input  logic              lst_in,
  input  logic              qclk_in,
  output logic              fst_out,
  output logic              lst_out,
  output logic              qclk_out,
  output logic              strobe_oe,
  output logic              qclk_oe
);

  logic wr_hit;
  logic strb_wr, qck_wr;
  logic strb_nxt, qck_nxt;
  logic apply;
  logic strb_act, qck_act;
  logic [1:0] dis_sync;
  logic [DATA_W-1:0] ctrl_word;
  logic unused_wdata;

  assign wr_hit = reg_wr && (reg_addr == CTRL_ADDR);
  assign strb_nxt = wr_hit ? reg_wdata[STRB_BIT] : strb_wr;
  assign qck_nxt  = wr_hit ? reg_wdata[QCK_BIT]  : qck_wr;
  assign apply = !retime_en || field_start;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_wr <= 1'b0;
      qck_wr  <= 1'b0;
    end else begin
      strb_wr <= strb_nxt;
      qck_wr  <= qck_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_act <= 1'b0;
      qck_act  <= 1'b0;
    end else if (apply) begin
      strb_act <= strb_nxt;
      qck_act  <= qck_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dis_sync <= 2'b00;
    else        dis_sync <= {dis_sync[0], ext_disable};
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[STRB_BIT] = strb_wr;
    ctrl_word[QCK_BIT]  = qck_wr;
  end

  assign reg_rdata = (reg_addr == CTRL_ADDR) ? ctrl_word : '0;

  assign strobe_oe = !(dis_sync[1] || strb_act);
  assign qclk_oe   = !(dis_sync[1] || qck_act);
  assign fst_out   = fst_in;
  assign lst_out   = lst_in;
  assign qclk_out  = qclk_in;

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (strb_wr == $past(reg_wdata[STRB_BIT])) && (qck_wr == $past(reg_wdata[QCK_BIT]))); // R2
  AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != CTRL_ADDR) |=> $stable(strb_wr) && $stable(qck_wr)); // R9
  AST_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    !retime_en |=> (strb_act == strb_wr) && (qck_act == qck_wr)); // R4
  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (retime_en && !field_start) |=> $stable(strb_act) && $stable(qck_act)); // R5
  AST_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (strb_act == strb_wr) && (qck_act == qck_wr)); // R6
  AST_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && $past(ext_disable, 2)) |-> (!strobe_oe && !qclk_oe)); // R7
  AST_BIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_act |-> !strobe_oe) and (qck_act |-> !qclk_oe)); // R8

endmodule

// File: tb/field_oe_ctrl_test.sv
module field_oe_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'h2;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic retime_en = 1'b0, field_start = 1'b0, ext_disable = 1'b0;
  logic fst_in = 1'b0, lst_in = 1'b0, qclk_in = 1'b0;
  logic fst_out, lst_out, qclk_out, strobe_oe, qclk_oe;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  field_oe_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .retime_en(retime_en),
    .field_start(field_start), .ext_disable(ext_disable),
    .fst_in(fst_in), .lst_in(lst_in), .qclk_in(qclk_in),
    .fst_out(fst_out), .lst_out(lst_out), .qclk_out(qclk_out),
    .strobe_oe(strobe_oe), .qclk_oe(qclk_oe));

  // {retime, wr, addr[3:0], wdata[7:0], field_start, exp_rdata[7:0], exp_strobe_oe, exp_qclk_oe}
  localparam int NV = 16;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'h2, 8'h20, 1'b0, 8'h20, 1'b0, 1'b1},
    {1'b0, 1'b1, 4'h2, 8'h40, 1'b0, 8'h40, 1'b1, 1'b0},
    {1'b0, 1'b1, 4'h2, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1},
    {1'b1, 1'b1, 4'h2, 8'h60, 1'b0, 8'h60, 1'b1, 1'b1},
    {1'b1, 1'b0, 4'h2, 8'h00, 1'b0, 8'h60, 1'b1, 1'b1},
    {1'b1, 1'b0, 4'h2, 8'h00, 1'b1, 8'h60, 1'b0, 1'b0},
    {1'b1, 1'b1, 4'h2, 8'h20, 1'b0, 8'h20, 1'b0, 1'b0},
    {1'b1, 1'b1, 4'h2, 8'h40, 1'b0, 8'h40, 1'b0, 1'b0},
    {1'b1, 1'b0, 4'h2, 8'h00, 1'b1, 8'h40, 1'b1, 1'b0},
    {1'b1, 1'b1, 4'h2, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b1, 4'h3, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b0, 4'h2, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b1, 4'h2, 8'h9F, 1'b0, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b1, 4'h2, 8'hFF, 1'b0, 8'h60, 1'b0, 1'b0},
    {1'b1, 1'b1, 4'h2, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'h2, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 1'b0; reg_addr = 4'h2; reg_wdata = 8'h00; field_start = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", {6'd0, strobe_oe, qclk_oe}, 8'h03);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 readback after reset", reg_rdata, 8'h00);
    chk("R1 oe after reset", {6'd0, strobe_oe, qclk_oe}, 8'h03);

    for (int i = 0; i < NV; i++) begin
      retime_en = VEC[i][24]; reg_wr = VEC[i][23]; reg_addr = VEC[i][22:19];
      reg_wdata = VEC[i][18:11]; field_start = VEC[i][10];
      @(negedge clk);
      chk($sformatf("R2 R3 R9 readback vec %0d", i), reg_rdata, VEC[i][9:2]);
      chk($sformatf("R4 R5 R6 R8 oe vec %0d", i), {6'd0, strobe_oe, qclk_oe}, {6'd0, VEC[i][1:0]});
    end
    idle();

    fst_in = 1'b1; lst_in = 1'b0; qclk_in = 1'b1;
    #1 chk("R10 pass-through a", {5'd0, fst_out, lst_out, qclk_out}, 8'h05);
    fst_in = 1'b0; lst_in = 1'b1; qclk_in = 1'b0;
    #1 chk("R10 pass-through b", {5'd0, fst_out, lst_out, qclk_out}, 8'h02);

    retime_en = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h20;
    @(negedge clk); idle();
    ext_disable = 1'b1;
    @(negedge clk);
    chk("R7 pin one cycle", {6'd0, strobe_oe, qclk_oe}, 8'h03);
    @(negedge clk);
    chk("R7 pin two cycles", {6'd0, strobe_oe, qclk_oe}, 8'h00);
    #1 chk("R10 data while disabled", {5'd0, fst_out, lst_out, qclk_out}, 8'h02);
    ext_disable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 pin released, bit pending", {6'd0, strobe_oe, qclk_oe}, 8'h03);
    field_start = 1'b1;
    @(negedge clk); idle();
    chk("R5 pending applied", {6'd0, strobe_oe, qclk_oe}, 8'h01);
    ext_disable = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 pin plus bit", {6'd0, strobe_oe, qclk_oe}, 8'h00);
    ext_disable = 1'b0;

    retime_en = 1'b0; reg_wr = 1'b1; reg_wdata = 8'h60;
    @(negedge clk); idle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 readback after mid reset", reg_rdata, 8'h00);
    chk("R1 oe after mid reset", {6'd0, strobe_oe, qclk_oe}, 8'h03);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule